// File: doc/BRIEF.md
# Bridge Transaction Window Router

This block makes the forwarding decision for one port of a PCIe-to-PCIe bridge. Every request that reaches the port is checked against three address windows: a 32-bit memory window, a 64-bit prefetchable memory window and an I/O window. The block also works out the request's direction from its requester ID. It then passes the request to the secondary side or the primary side, hands it to the interrupt logic, or answers it with a completion. Configuration and message requests are routed by their type and routing code instead of by address.

A narrow write port reloads the window bounds, one 32-bit word per write. Requests arrive over a valid/ready handshake. The block takes one request at a time, and a request is accepted only in state `ST_IDLE`. The accepting edge (transition `IDLE->ISSUE`) registers the decision. During the one cycle in `ST_ISSUE`, exactly one of four strobes is high, and the shared output fields hold the request. The block then returns to `ST_IDLE` unconditionally (transition `ISSUE->IDLE`). The bus-number and device/function inputs are straps and must be held stable while the block is in use.

Top module: `bridge_window_router`

## Requirements
- R1: A request from outside the bus range [sec_bus, sub_bus] is downstream-directed. A downstream memory request (kind 0) goes to the secondary side (`sec_valid`) only when its address lies in [mem base, mem limit) or in [pf base, pf limit). Otherwise it completes with Unsupported Request.
- R2: An upstream-directed memory request goes to the primary side (`pri_valid`) only when its address lies outside both memory windows. Otherwise it completes with Unsupported Request.
- R3: I/O requests (kind 1) follow the R1/R2 rules against the single window [io base, io limit).
- R4: Every completion carries `cpl_cid` = {pri_bus, own_devfn}. `out_rid` on a completion is the original requester ID. Status codes are 0 = Successful, 1 = Unsupported Request, 4 = Completer Abort.
- R5: A requester counts as upstream-directed exactly when its bus number (`req_rid[15:8]`) satisfies sec_bus <= bus <= sub_bus. Both range ends are inclusive.
- R6: A Type 1 configuration request (kind 3) always goes to the secondary side, with `out_rid` replaced by {pri_bus, own_devfn}.
- R7: A Type 0 configuration request (kind 2) at offset 0x1000 or above completes with Unsupported Request. Below 0x1000 it completes with Successful Completion, or with Completer Abort when `req_cfg_err` is set. It is never forwarded.
- R8: A window write (`wr_sel`: 0 mem base, 1 mem limit, 2 pf base low word, 3 pf base high word, 4 pf limit low, 5 pf limit high, 6 io base, 7 io limit) takes effect for requests accepted after the write edge. A window with base >= limit matches no address.
- R9: Messages (kind 4) are routed by `req_route`. Codes 0 (to root) and 5 (gathered to root) go to the primary side. Code 3 (broadcast) goes to the secondary side. Code 4 (local) with a message code in 0x20..0x27 (INTx assert/deassert) goes to `intx_valid`. Every other route code, or a local message outside that range, completes with Unsupported Request.
- R10: A request is accepted only when `req_ready` is high. The decision appears on the strobes in the cycle after the accepting edge, and `req_ready` is low in that cycle.
- R11: A request kind of 5, 6 or 7 completes with Unsupported Request.
- R12: Each accepted request raises exactly one strobe, for exactly one cycle. No strobe rises without an accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pri_bus | input | 8 | Primary bus number strap |
| sec_bus | input | 8 | Secondary bus number strap |
| sub_bus | input | 8 | Subordinate bus number strap |
| own_devfn | input | 8 | Device/function number of the bridge |
| wr_en | input | 1 | Window write strobe |
| wr_sel | input | 3 | Window word select |
| wr_data | input | 32 | Window write data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_kind | input | 3 | 0 mem, 1 I/O, 2 cfg type 0, 3 cfg type 1, 4 message |
| req_addr | input | 64 | Address, config offset or message target |
| req_rid | input | 16 | Requester ID (bus in upper byte) |
| req_route | input | 3 | Message routing code |
| req_code | input | 8 | Message code |
| req_cfg_err | input | 1 | Local config access failed |
| sec_valid | output | 1 | Forward to secondary side |
| pri_valid | output | 1 | Forward to primary side |
| cpl_valid | output | 1 | Completion returned |
| intx_valid | output | 1 | Local INTx message for interrupt logic |
| out_kind | output | 3 | Kind of the issued request |
| out_addr | output | 64 | Address of the issued request |
| out_rid | output | 16 | Requester ID, possibly replaced |
| out_code | output | 8 | Message code of the issued request |
| cpl_status | output | 3 | Completion status |
| cpl_cid | output | 16 | Completer ID |

## Verification
The hardest case to reach from the ports is a second request held valid through the issue cycle of the first. It must stay unaccepted for that cycle and then be taken on the next edge. The stimulus keeps `req_valid` high, swaps the fields during the issue cycle, and checks both decisions in turn. Window and bus-range edges come next. Each is driven at the exact base, at limit minus one and at the limit, and requester buses sit exactly on sec_bus and sub_bus and one past. A window is also reloaded between two otherwise identical requests, so that the same address changes its outcome.

// File: rtl/br_pkg.sv
package br_pkg;
    localparam logic [2:0] KIND_MEM  = 3'd0;
    localparam logic [2:0] KIND_IO   = 3'd1;
    localparam logic [2:0] KIND_CFG0 = 3'd2;
    localparam logic [2:0] KIND_CFG1 = 3'd3;
    localparam logic [2:0] KIND_MSG  = 3'd4;

    localparam logic [2:0] RT_TO_ROOT = 3'd0;
    localparam logic [2:0] RT_BCAST   = 3'd3;
    localparam logic [2:0] RT_LOCAL   = 3'd4;
    localparam logic [2:0] RT_GATHER  = 3'd5;

    localparam logic [2:0] CPL_SC = 3'd0;
    localparam logic [2:0] CPL_UR = 3'd1;
    localparam logic [2:0] CPL_CA = 3'd4;

    localparam logic [7:0] INTX_FIRST = 8'h20;
    localparam logic [7:0] INTX_LAST  = 8'h27;

    localparam logic [2:0] SEL_MEM_BASE   = 3'd0;
    localparam logic [2:0] SEL_MEM_LIMIT  = 3'd1;
    localparam logic [2:0] SEL_PF_BASE_L  = 3'd2;
    localparam logic [2:0] SEL_PF_BASE_H  = 3'd3;
    localparam logic [2:0] SEL_PF_LIMIT_L = 3'd4;
    localparam logic [2:0] SEL_PF_LIMIT_H = 3'd5;
    localparam logic [2:0] SEL_IO_BASE    = 3'd6;
    localparam logic [2:0] SEL_IO_LIMIT   = 3'd7;

    typedef enum logic [2:0] {
        DST_NONE, DST_SEC, DST_PRI, DST_CPL, DST_INTX
    } dest_e;

    typedef enum logic {
        ST_IDLE, ST_ISSUE
    } state_e;
endpackage

// File: rtl/br_window_regs.sv
module br_window_regs #(
    parameter int WR_W  = 32,
    parameter int MEM_W = 32,
    parameter int PF_W  = 64,
    parameter int IO_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [WR_W-1:0]   wr_data,
    output logic [MEM_W-1:0]  mem_base,
    output logic [MEM_W-1:0]  mem_limit,
    output logic [PF_W-1:0]   pf_base,
    output logic [PF_W-1:0]   pf_limit,
    output logic [IO_W-1:0]   io_base,
    output logic [IO_W-1:0]   io_limit
);
    import br_pkg::*;

    localparam int PF_HI_W = PF_W - WR_W;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_base  <= '0;
            mem_limit <= '0;
            pf_base   <= '0;
            pf_limit  <= '0;
            io_base   <= '0;
            io_limit  <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_MEM_BASE:   mem_base  <= wr_data[MEM_W-1:0];
                SEL_MEM_LIMIT:  mem_limit <= wr_data[MEM_W-1:0];
                SEL_PF_BASE_L:  pf_base[WR_W-1:0]     <= wr_data;
                SEL_PF_BASE_H:  pf_base[PF_W-1:WR_W]  <= wr_data[PF_HI_W-1:0];
                SEL_PF_LIMIT_L: pf_limit[WR_W-1:0]    <= wr_data;
                SEL_PF_LIMIT_H: pf_limit[PF_W-1:WR_W] <= wr_data[PF_HI_W-1:0];
                SEL_IO_BASE:    io_base   <= wr_data[IO_W-1:0];
                default:        io_limit  <= wr_data[IO_W-1:0];
            endcase
        end
    end
endmodule

// File: rtl/br_window_check.sv
module br_window_check #(
    parameter int ADDR_W = 64,
    parameter int WIN_W  = 32
) (
    input  logic [WIN_W-1:0]  base,
    input  logic [WIN_W-1:0]  limit,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    logic upper_zero;
    logic enabled;
    logic in_low;

    generate
        if (WIN_W < ADDR_W) begin : g_narrow
            assign upper_zero = (addr[ADDR_W-1:WIN_W] == '0);
        end else begin : g_full
            assign upper_zero = 1'b1;
        end
    endgenerate

    assign enabled = (base < limit);
    assign in_low  = (addr[WIN_W-1:0] >= base) && (addr[WIN_W-1:0] < limit);
    assign hit     = enabled && upper_zero && in_low;
endmodule

// File: rtl/br_route_decide.sv
module br_route_decide #(
    parameter int ADDR_W    = 64,
    parameter int BUS_W     = 8,
    parameter int CFG_SPACE = 4096
) (
    input  logic [2:0]          kind,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [2*BUS_W-1:0]  rid,
    input  logic [2:0]          route,
    input  logic [7:0]          code,
    input  logic                cfg_err,
    input  logic [BUS_W-1:0]    sec_bus,
    input  logic [BUS_W-1:0]    sub_bus,
    input  logic [2*BUS_W-1:0]  own_id,
    input  logic                mem_hit,
    input  logic                pf_hit,
    input  logic                io_hit,
    output br_pkg::dest_e       dest,
    output logic [2:0]          status,
    output logic [2*BUS_W-1:0]  rid_out
);
    import br_pkg::*;

    localparam logic [ADDR_W-1:0] CFG_END = ADDR_W'(CFG_SPACE);

    logic [BUS_W-1:0] req_bus;
    logic             upward;
    logic             mem_any;

    assign req_bus = rid[2*BUS_W-1:BUS_W];
    assign upward  = (req_bus >= sec_bus) && (req_bus <= sub_bus);
    assign mem_any = mem_hit || pf_hit;

    always_comb begin
        dest    = DST_CPL;
        status  = CPL_UR;
        rid_out = rid;
        case (kind)
            KIND_MEM: begin
                if (!upward && mem_any)      dest = DST_SEC;
                else if (upward && !mem_any) dest = DST_PRI;
            end
            KIND_IO: begin
                if (!upward && io_hit)       dest = DST_SEC;
                else if (upward && !io_hit)  dest = DST_PRI;
            end
            KIND_CFG1: begin
                dest    = DST_SEC;
                rid_out = own_id;
            end
            KIND_CFG0: begin
                if (addr < CFG_END) status = cfg_err ? CPL_CA : CPL_SC;
            end
            KIND_MSG: begin
                case (route)
                    RT_TO_ROOT, RT_GATHER: dest = DST_PRI;
                    RT_BCAST:              dest = DST_SEC;
                    RT_LOCAL: begin
                        if (code >= INTX_FIRST && code <= INTX_LAST) dest = DST_INTX;
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bridge_window_router.sv
module bridge_window_router #(
    parameter int ADDR_W    = 64,
    parameter int BUS_W     = 8,
    parameter int WR_W      = 32,
    parameter int MEM_W     = 32,
    parameter int PF_W      = 64,
    parameter int IO_W      = 32,
    parameter int CFG_SPACE = 4096
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BUS_W-1:0]     pri_bus,
    input  logic [BUS_W-1:0]     sec_bus,
    input  logic [BUS_W-1:0]     sub_bus,
    input  logic [BUS_W-1:0]     own_devfn,
    input  logic                 wr_en,
    input  logic [2:0]           wr_sel,
    input  logic [WR_W-1:0]      wr_data,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [2:0]           req_kind,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [2*BUS_W-1:0]   req_rid,
    input  logic [2:0]           req_route,
    input  logic [7:0]           req_code,
    input  logic                 req_cfg_err,
    output logic                 sec_valid,
    output logic                 pri_valid,
    output logic                 cpl_valid,
    output logic                 intx_valid,
    output logic [2:0]           out_kind,
    output logic [ADDR_W-1:0]    out_addr,
    output logic [2*BUS_W-1:0]   out_rid,
    output logic [7:0]           out_code,
    output logic [2:0]           cpl_status,
    output logic [2*BUS_W-1:0]   cpl_cid
);
    import br_pkg::*;

    localparam int ID_W = 2 * BUS_W;

    state_e            state, state_nxt;
    dest_e             dst_q;
    dest_e             dst_d;
    logic [2:0]        status_d;
    logic [ID_W-1:0]   rid_d;
    logic [ID_W-1:0]   own_id;
    logic              take;

    logic [MEM_W-1:0]  mem_base, mem_limit;
    logic [PF_W-1:0]   pf_base, pf_limit;
    logic [IO_W-1:0]   io_base, io_limit;
    logic              mem_hit, pf_hit, io_hit;

    assign own_id = {pri_bus, own_devfn};

    br_window_regs #(
        .WR_W(WR_W), .MEM_W(MEM_W), .PF_W(PF_W), .IO_W(IO_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .mem_base(mem_base), .mem_limit(mem_limit),
        .pf_base(pf_base), .pf_limit(pf_limit),
        .io_base(io_base), .io_limit(io_limit)
    );

    br_window_check #(.ADDR_W(ADDR_W), .WIN_W(MEM_W)) u_mem_win (
        .base(mem_base), .limit(mem_limit), .addr(req_addr), .hit(mem_hit)
    );
    br_window_check #(.ADDR_W(ADDR_W), .WIN_W(PF_W)) u_pf_win (
        .base(pf_base), .limit(pf_limit), .addr(req_addr), .hit(pf_hit)
    );
    br_window_check #(.ADDR_W(ADDR_W), .WIN_W(IO_W)) u_io_win (
        .base(io_base), .limit(io_limit), .addr(req_addr), .hit(io_hit)
    );

    br_route_decide #(
        .ADDR_W(ADDR_W), .BUS_W(BUS_W), .CFG_SPACE(CFG_SPACE)
    ) u_decide (
        .kind(req_kind), .addr(req_addr), .rid(req_rid),
        .route(req_route), .code(req_code), .cfg_err(req_cfg_err),
        .sec_bus(sec_bus), .sub_bus(sub_bus), .own_id(own_id),
        .mem_hit(mem_hit), .pf_hit(pf_hit), .io_hit(io_hit),
        .dest(dst_d), .status(status_d), .rid_out(rid_d)
    );

    assign take = (state == ST_IDLE) && req_valid;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_nxt = ST_ISSUE;
            ST_ISSUE: state_nxt = ST_IDLE;
        endcase
    end

    // decision capture on handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_q      <= DST_NONE;
            cpl_status <= CPL_SC;
            out_kind   <= '0;
            out_addr   <= '0;
            out_rid    <= '0;
            out_code   <= '0;
            cpl_cid    <= '0;
        end else if (take) begin
            dst_q      <= dst_d;
            cpl_status <= status_d;
            out_kind   <= req_kind;
            out_addr   <= req_addr;
            out_rid    <= rid_d;
            out_code   <= req_code;
            cpl_cid    <= own_id;
        end
    end

    // outputs
    always_comb begin
        req_ready  = 1'b0;
        sec_valid  = 1'b0;
        pri_valid  = 1'b0;
        cpl_valid  = 1'b0;
        intx_valid = 1'b0;
        unique case (state)
            ST_IDLE:  req_ready = 1'b1;
            ST_ISSUE: begin
                sec_valid  = (dst_q == DST_SEC);
                pri_valid  = (dst_q == DST_PRI);
                cpl_valid  = (dst_q == DST_CPL);
                intx_valid = (dst_q == DST_INTX);
            end
        endcase
    end
endmodule

// File: rtl/br_router_checker.sv
module br_router_checker #(
    parameter int BUS_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [BUS_W-1:0]   pri_bus,
    input logic [BUS_W-1:0]   own_devfn,
    input logic               req_valid,
    input logic               req_ready,
    input logic               sec_valid,
    input logic               pri_valid,
    input logic               cpl_valid,
    input logic               intx_valid,
    input logic [2:0]         out_kind,
    input logic [2*BUS_W-1:0] out_rid,
    input logic [2*BUS_W-1:0] cpl_cid
);
    import br_pkg::*;

    logic [3:0] strobes;
    assign strobes = {sec_valid, pri_valid, cpl_valid, intx_valid};

    a_r12_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobes));

    a_r12_strobe_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ($countones(strobes) == 1));

    a_r12_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (strobes != 4'b0) |=> (strobes == 4'b0));

    a_r10_busy_while_issuing: assert property (@(posedge clk) disable iff (!rst_n)
        (strobes != 4'b0) |-> !req_ready);

    a_r4_completer_id: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> (cpl_cid == {$past(pri_bus), $past(own_devfn)}));

    a_r6_cfg1_own_rid: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_valid && out_kind == KIND_CFG1) |-> (out_rid == {$past(pri_bus), $past(own_devfn)}));

    a_r7_cfg0_local: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_valid || pri_valid) |-> (out_kind != KIND_CFG0));

    a_r9_intx_is_msg: assert property (@(posedge clk) disable iff (!rst_n)
        intx_valid |-> (out_kind == KIND_MSG));
endmodule

bind bridge_window_router br_router_checker #(.BUS_W(BUS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pri_bus(pri_bus), .own_devfn(own_devfn),
    .req_valid(req_valid), .req_ready(req_ready),
    .sec_valid(sec_valid), .pri_valid(pri_valid),
    .cpl_valid(cpl_valid), .intx_valid(intx_valid),
    .out_kind(out_kind), .out_rid(out_rid), .cpl_cid(cpl_cid)
);

// File: tb/tb_bridge_window_router.sv
module tb_bridge_window_router;
    localparam logic [7:0] PRI = 8'h01, SEC = 8'h02, SUB = 8'h05, DEVFN = 8'h08;
    localparam logic [15:0] OWN = {PRI, DEVFN};
    localparam int D_SEC = 1, D_PRI = 2, D_CPL = 3, D_INTX = 4;

    logic clk = 0;
    logic rst_n = 0;
    logic wr_en = 0;
    logic [2:0] wr_sel = 0;
    logic [31:0] wr_data = 0;
    logic req_valid = 0;
    logic [2:0] req_kind = 0;
    logic [63:0] req_addr = 0;
    logic [15:0] req_rid = 0;
    logic [2:0] req_route = 0;
    logic [7:0] req_code = 0;
    logic req_cfg_err = 0;
    logic req_ready, sec_valid, pri_valid, cpl_valid, intx_valid;
    logic [2:0] out_kind, cpl_status;
    logic [63:0] out_addr;
    logic [15:0] out_rid, cpl_cid;
    logic [7:0] out_code;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // reference window copies
    longint unsigned m_mb = 0, m_ml = 0, m_pb = 0, m_pl = 0, m_ib = 0, m_il = 0;

    always #2 clk = ~clk;

    bridge_window_router dut (
        .clk(clk), .rst_n(rst_n), .pri_bus(PRI), .sec_bus(SEC), .sub_bus(SUB),
        .own_devfn(DEVFN), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_addr(req_addr), .req_rid(req_rid), .req_route(req_route),
        .req_code(req_code), .req_cfg_err(req_cfg_err),
        .sec_valid(sec_valid), .pri_valid(pri_valid), .cpl_valid(cpl_valid),
        .intx_valid(intx_valid), .out_kind(out_kind), .out_addr(out_addr),
        .out_rid(out_rid), .out_code(out_code), .cpl_status(cpl_status),
        .cpl_cid(cpl_cid)
    );

    task automatic cmp(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // behavioural reference
    task automatic model(input logic [2:0] k, input logic [63:0] a, input logic [15:0] r,
                         input logic [2:0] rt, input logic [7:0] c, input bit e,
                         output int d, output logic [2:0] st, output logic [15:0] ro);
        bit up, inm, ini;
        up  = (r[15:8] >= SEC) && (r[15:8] <= SUB);
        inm = (a >= m_mb && a < m_ml) || (a >= m_pb && a < m_pl);
        ini = (a >= m_ib && a < m_il);
        d = D_CPL; st = 3'd1; ro = r;
        if (k == 0) begin
            if (!up && inm) d = D_SEC; else if (up && !inm) d = D_PRI;
        end else if (k == 1) begin
            if (!up && ini) d = D_SEC; else if (up && !ini) d = D_PRI;
        end else if (k == 3) begin
            d = D_SEC; ro = OWN;
        end else if (k == 2) begin
            if (a < 64'h1000) st = e ? 3'd4 : 3'd0;
        end else if (k == 4) begin
            if (rt == 0 || rt == 5) d = D_PRI;
            else if (rt == 3) d = D_SEC;
            else if (rt == 4 && c >= 8'h20 && c <= 8'h27) d = D_INTX;
        end
    endtask

    task automatic check_issue(input string req, input int d, input logic [2:0] st,
                               input logic [15:0] ro, input logic [2:0] k,
                               input logic [63:0] a, input logic [7:0] c);
        logic [3:0] exp_s;
        exp_s = (d == D_SEC) ? 4'b1000 : (d == D_PRI) ? 4'b0100 : (d == D_CPL) ? 4'b0010 : 4'b0001;
        cmp(req, "strobes", {60'd0, sec_valid, pri_valid, cpl_valid, intx_valid}, {60'd0, exp_s});
        cmp(req, "ready in issue", {63'd0, req_ready}, 64'd0);
        if (d == D_CPL) begin
            cmp(req, "cpl_status", {61'd0, cpl_status}, {61'd0, st});
            cmp(req, "cpl_cid", {48'd0, cpl_cid}, {48'd0, OWN});
            cmp(req, "cpl requester", {48'd0, out_rid}, {48'd0, ro});
        end else if (d == D_INTX) begin
            cmp(req, "intx code", {56'd0, out_code}, {56'd0, c});
        end else begin
            cmp(req, "out_kind", {61'd0, out_kind}, {61'd0, k});
            cmp(req, "out_addr", out_addr, a);
            cmp(req, "out_rid", {48'd0, out_rid}, {48'd0, ro});
        end
    endtask

    task automatic drive(input logic [2:0] k, input logic [63:0] a, input logic [15:0] r,
                         input logic [2:0] rt, input logic [7:0] c, input bit e);
        req_valid = 1; req_kind = k; req_addr = a; req_rid = r;
        req_route = rt; req_code = c; req_cfg_err = e;
    endtask

    task automatic send(input string req, input logic [2:0] k, input logic [63:0] a,
                        input logic [15:0] r, input logic [2:0] rt, input logic [7:0] c, input bit e);
        int d; logic [2:0] st; logic [15:0] ro;
        model(k, a, r, rt, c, e, d, st, ro);
        @(negedge clk);
        cmp(req, "ready idle", {63'd0, req_ready}, 64'd1);
        drive(k, a, r, rt, c, e);
        @(negedge clk);
        check_issue(req, d, st, ro, k, a, c);
        req_valid = 0;
        @(negedge clk);
        cmp(req, "quiet after issue", {60'd0, sec_valid, pri_valid, cpl_valid, intx_valid}, 64'd0);
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1; wr_sel = s; wr_data = v;
        @(negedge clk);
        wr_en = 0;
        case (s)
            3'd0: m_mb = {32'd0, v};
            3'd1: m_ml = {32'd0, v};
            3'd2: m_pb = {m_pb[63:32], v};
            3'd3: m_pb = {v, m_pb[31:0]};
            3'd4: m_pl = {m_pl[63:32], v};
            3'd5: m_pl = {v, m_pl[31:0]};
            3'd6: m_ib = {32'd0, v};
            default: m_il = {32'd0, v};
        endcase
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int d; logic [2:0] st; logic [15:0] ro;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state (R10, R12)
        cmp("R10", "reset ready", {63'd0, req_ready}, 64'd1);
        cmp("R12", "reset strobes", {60'd0, sec_valid, pri_valid, cpl_valid, intx_valid}, 64'd0);
        cmp("R4", "reset cid", {48'd0, cpl_cid}, 64'd0);

        // R8: all windows disabled after reset; upstream mem passes, downstream mem rejected
        send("R8", 3'd0, 64'h8000_0000, 16'h0010, 0, 0, 0);
        send("R8", 3'd0, 64'h8000_0000, 16'h0300, 0, 0, 0);

        wr(3'd0, 32'h8000_0000); wr(3'd1, 32'h9000_0000);
        wr(3'd2, 32'h0000_0000); wr(3'd3, 32'h0000_0001);
        wr(3'd4, 32'h0000_0000); wr(3'd5, 32'h0000_0002);
        wr(3'd6, 32'h0000_1000); wr(3'd7, 32'h0000_2000);

        // R1 downstream memory
        send("R1", 3'd0, 64'h8000_0000, 16'h0010, 0, 0, 0);
        send("R1", 3'd0, 64'h8FFF_FFFF, 16'h0010, 0, 0, 0);
        send("R1", 3'd0, 64'h9000_0000, 16'h0010, 0, 0, 0);
        send("R1", 3'd0, 64'h1_8000_0000, 16'h0010, 0, 0, 0);
        send("R1", 3'd0, 64'h2_0000_0000, 16'h0010, 0, 0, 0);
        // R2 upstream memory
        send("R2", 3'd0, 64'h7000_0000, 16'h0300, 0, 0, 0);
        send("R2", 3'd0, 64'h8000_0010, 16'h0300, 0, 0, 0);
        send("R2", 3'd0, 64'h1_0000_0000, 16'h0300, 0, 0, 0);
        send("R2", 3'd0, 64'h2_0000_0000, 16'h0300, 0, 0, 0);
        // R3 I/O
        send("R3", 3'd1, 64'h1000, 16'h0010, 0, 0, 0);
        send("R3", 3'd1, 64'h2000, 16'h0010, 0, 0, 0);
        send("R3", 3'd1, 64'h1800, 16'h0300, 0, 0, 0);
        send("R3", 3'd1, 64'h3000, 16'h0300, 0, 0, 0);
        // R5 bus range edges, R4 completion ids
        send("R5", 3'd0, 64'h7000_0000, 16'h0200, 0, 0, 0);
        send("R5", 3'd0, 64'h7000_0000, 16'h0500, 0, 0, 0);
        send("R5", 3'd0, 64'h7000_0000, 16'h0600, 0, 0, 0);
        send("R4", 3'd0, 64'h8000_0000, 16'h04AB, 0, 0, 0);
        // R6 type 1 config
        send("R6", 3'd3, 64'h0000_0040, 16'h0010, 0, 0, 0);
        // R7 type 0 config
        send("R7", 3'd2, 64'h0FFC, 16'h0010, 0, 0, 0);
        send("R7", 3'd2, 64'h0FFC, 16'h0010, 0, 0, 1);
        send("R7", 3'd2, 64'h1000, 16'h0010, 0, 0, 0);
        // R9 messages
        send("R9", 3'd4, 64'h0, 16'h0300, 3'd0, 8'h30, 0);
        send("R9", 3'd4, 64'h0, 16'h0300, 3'd5, 8'h31, 0);
        send("R9", 3'd4, 64'h0, 16'h0010, 3'd3, 8'h32, 0);
        send("R9", 3'd4, 64'h0, 16'h0010, 3'd1, 8'h33, 0);
        send("R9", 3'd4, 64'h0, 16'h0010, 3'd2, 8'h34, 0);
        send("R9", 3'd4, 64'h0, 16'h0300, 3'd4, 8'h20, 0);
        send("R9", 3'd4, 64'h0, 16'h0300, 3'd4, 8'h27, 0);
        send("R9", 3'd4, 64'h0, 16'h0300, 3'd4, 8'h1F, 0);
        // R11 reserved kinds
        send("R11", 3'd5, 64'h8000_0000, 16'h0010, 0, 0, 0);
        send("R11", 3'd7, 64'h8000_0000, 16'h0300, 0, 0, 0);
        // R8 reload shrinks memory window, then disable I/O window
        wr(3'd1, 32'h8800_0000);
        send("R8", 3'd0, 64'h8900_0000, 16'h0010, 0, 0, 0);
        send("R8", 3'd0, 64'h8900_0000, 16'h0300, 0, 0, 0);
        wr(3'd7, 32'h0000_1000);
        send("R8", 3'd1, 64'h1000, 16'h0010, 0, 0, 0);
        send("R8", 3'd1, 64'h1000, 16'h0300, 0, 0, 0);

        // R10 back-to-back: second request held valid through the issue cycle
        @(negedge clk);
        drive(3'd0, 64'h8000_0000, 16'h0010, 0, 0, 0);
        @(negedge clk);
        model(3'd0, 64'h8000_0000, 16'h0010, 0, 0, 0, d, st, ro);
        check_issue("R10", d, st, ro, 3'd0, 64'h8000_0000, 8'h00);
        drive(3'd1, 64'h5000, 16'h0300, 0, 0, 0);
        @(negedge clk);
        cmp("R10", "ready after issue", {63'd0, req_ready}, 64'd1);
        cmp("R10", "no early strobe", {60'd0, sec_valid, pri_valid, cpl_valid, intx_valid}, 64'd0);
        @(negedge clk);
        model(3'd1, 64'h5000, 16'h0300, 0, 0, 0, d, st, ro);
        check_issue("R10", d, st, ro, 3'd1, 64'h5000, 8'h00);
        req_valid = 0;
        @(negedge clk);
        cmp("R12", "quiet", {60'd0, sec_valid, pri_valid, cpl_valid, intx_valid}, 64'd0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule